// File: doc/BRIEF.md
# Single-Accumulator Multi-Cycle Processor Core

This block is a small processor core. It holds a single accumulator and steps every instruction through a fixed chain of register transfers. Four internal registers carry each instruction from memory to the execution step: a program counter, an instruction register, an effective-address register that always drives the memory address, and a memory buffer register that captures every word read back. Each instruction names one memory operand. The data operations read the accumulator and write their result back into it.

The core connects to one synchronous, word-addressed memory port. The port has separate read and write strobes and returns read data one cycle after the read strobe. A 12-bit address reaches 4096 words. The instruction word is 16 bits: the opcode sits in bits 15:12 and the operand address in bits 11:0. The opcodes are 0 halt, 1 load, 2 add, 3 subtract, 4 AND and 5 store. The values 6 to 15 do nothing. After a halt the core holds still and raises a status output until the next reset.

Top module: `acc_cpu_core`

## Requirements
- R1: While `rst_n` is low, `halted`, `mem_rd` and `mem_wr` are 0. After reset the program counter and the accumulator are zero, so the first fetch reads address 0.
- R2: Every instruction starts with one cycle that has no strobe. In the second cycle `mem_rd` is 1. The word returned in the following cycle is taken as the instruction.
- R3: The address of each instruction fetch is exactly one more than the address of the previous fetch, wrapping modulo 4096.
- R4: Load, add, subtract and AND take 9 cycles. In the 7th cycle they assert `mem_rd` with `mem_addr` equal to the instruction's bits 11:0.
- R5: Opcode 1 (load) copies the operand word into the accumulator.
- R6: Opcode 2 (add) writes the accumulator plus the operand, modulo 2^16, into the accumulator.
- R7: Opcode 3 (subtract) writes the accumulator minus the operand, modulo 2^16, into the accumulator.
- R8: Opcode 4 (AND) writes the bitwise AND of the accumulator and the operand into the accumulator.
- R9: Opcode 5 (store) takes 7 cycles. It asserts `mem_wr` for exactly one cycle, the 7th, with `mem_addr` equal to bits 11:0 and `mem_wdata` equal to the accumulator. `mem_rd` and `mem_wr` are never high together.
- R10: For opcode 0 (halt), `halted` rises in the 7th cycle of the instruction and stays high until reset. No strobe is issued while `halted` is high.
- R11: Opcodes 6 to 15 take 6 cycles. They issue no strobe after the fetch and leave the accumulator unchanged. The next fetch follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_addr | output | 12 | Word address, driven by the effective-address register |
| mem_rd | output | 1 | Read strobe; data is expected on `mem_rdata` one cycle later |
| mem_rdata | input | 16 | Read data returned by the memory |
| mem_wr | output | 1 | Write strobe, one cycle per store |
| mem_wdata | output | 16 | Write data, equal to the accumulator |
| halted | output | 1 | High once a halt has executed |

## Verification
A sequencer state that is wrong shows up within one instruction. The strobes then land in the wrong cycle of the instruction, and a cycle-accurate comparison of `mem_rd`, `mem_wr` and `halted` flags it at once. A wrong program counter or a wrong effective address shows up at the next strobe as a wrong `mem_addr`. A wrong accumulator value stays hidden until a store puts it on `mem_wdata`, so every arithmetic test program stores each result straight after computing it. A halt that leaks through, or an undefined opcode that changes state, is caught by a word placed after the halt or the no-op. That word must not be written, and it must hold the value the bench expects.

// File: rtl/acc_pkg.sv
package acc_pkg;

  localparam int unsigned OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OPC_HALT  = 4'd0,
    OPC_LOAD  = 4'd1,
    OPC_ADD   = 4'd2,
    OPC_SUB   = 4'd3,
    OPC_AND   = 4'd4,
    OPC_STORE = 4'd5
  } opc_e;

  typedef enum logic [3:0] {
    ST_F_EAR   = 4'd0,
    ST_F_READ  = 4'd1,
    ST_F_MBR   = 4'd2,
    ST_F_IR    = 4'd3,
    ST_PC_STEP = 4'd4,
    ST_O_EAR   = 4'd5,
    ST_O_READ  = 4'd6,
    ST_O_MBR   = 4'd7,
    ST_EXEC    = 4'd8,
    ST_WRITE   = 4'd9,
    ST_STOP    = 4'd10
  } seq_state_e;

  typedef struct packed {
    logic ear_from_pc;
    logic ear_from_ir;
    logic mbr_ld;
    logic ir_ld;
    logic pc_inc;
    logic acc_ld;
    logic rd;
    logic wr;
  } seq_ctl_t;

  function automatic logic opc_uses_operand(input logic [OPC_W-1:0] o);
    return (o == OPC_LOAD) || (o == OPC_ADD) || (o == OPC_SUB) || (o == OPC_AND);
  endfunction

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [WORD_W-1:0] acc_in,
  input  logic [WORD_W-1:0] opnd,
  output logic [WORD_W-1:0] result
);

  function automatic logic [WORD_W-1:0] acc_op(
    input logic [OPC_W-1:0]  o,
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b
  );
    logic [WORD_W-1:0] r;
    case (o)
      OPC_LOAD: r = b;
      OPC_ADD:  r = a + b;
      OPC_SUB:  r = a - b;
      OPC_AND:  r = a & b;
      default:  r = a;
    endcase
    return r;
  endfunction

  assign result = acc_op(opc, acc_in, opnd);

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opc,
  output seq_ctl_t         ctl,
  output logic             halted
);

  seq_state_e state_q, state_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_F_EAR;
    else        state_q <= state_d;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_F_EAR:   state_d = ST_F_READ;
      ST_F_READ:  state_d = ST_F_MBR;
      ST_F_MBR:   state_d = ST_F_IR;
      ST_F_IR:    state_d = ST_PC_STEP;
      ST_PC_STEP: state_d = ST_O_EAR;
      ST_O_EAR: begin
        if (opc == OPC_HALT)          state_d = ST_STOP;
        else if (opc == OPC_STORE)    state_d = ST_WRITE;
        else if (opc_uses_operand(opc)) state_d = ST_O_READ;
        else                          state_d = ST_F_EAR;
      end
      ST_O_READ:  state_d = ST_O_MBR;
      ST_O_MBR:   state_d = ST_EXEC;
      ST_EXEC:    state_d = ST_F_EAR;
      ST_WRITE:   state_d = ST_F_EAR;
      ST_STOP:    state_d = ST_STOP;
      default:    state_d = ST_F_EAR;
    endcase
  end

  always_comb begin
    ctl = '0;
    case (state_q)
      ST_F_EAR:   ctl.ear_from_pc = 1'b1;
      ST_F_READ:  ctl.rd          = 1'b1;
      ST_F_MBR:   ctl.mbr_ld      = 1'b1;
      ST_F_IR:    ctl.ir_ld       = 1'b1;
      ST_PC_STEP: ctl.pc_inc      = 1'b1;
      ST_O_EAR:   ctl.ear_from_ir = 1'b1;
      ST_O_READ:  ctl.rd          = 1'b1;
      ST_O_MBR:   ctl.mbr_ld      = 1'b1;
      ST_EXEC:    ctl.acc_ld      = 1'b1;
      ST_WRITE:   ctl.wr          = 1'b1;
      default:    ctl = '0;
    endcase
  end

  assign halted = (state_q == ST_STOP);

  assert_wr_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.wr |=> !ctl.wr);
  assert_rd_wr_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl.rd && ctl.wr));
  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!ctl.rd && !ctl.wr && !ctl.acc_ld && !ctl.pc_inc));
  assert_read_then_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rd |=> ctl.mbr_ld);

endmodule

// File: rtl/acc_regs.sv
module acc_regs
  import acc_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_ctl_t          ctl,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic [WORD_W-1:0] alu_y,
  output logic [ADDR_W-1:0] ear,
  output logic [WORD_W-1:0] acc,
  output logic [WORD_W-1:0] mbr,
  output logic [OPC_W-1:0]  ir_opc
);

  logic [ADDR_W-1:0] pc;
  logic [WORD_W-1:0] ir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (ctl.pc_inc) pc <= pc + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ear <= '0;
    else if (ctl.ear_from_pc) ear <= pc;
    else if (ctl.ear_from_ir) ear <= ir[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          mbr <= '0;
    else if (ctl.mbr_ld) mbr <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ir <= '0;
    else if (ctl.ir_ld) ir <= mbr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          acc <= '0;
    else if (ctl.acc_ld) acc <= alu_y;
  end

  assign ir_opc = ir[WORD_W-1 -: OPC_W];

  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.pc_inc |=> (pc == $past(pc) + 1'b1));
  assert_acc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.acc_ld |=> $stable(acc));
  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.pc_inc |=> $stable(pc));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_pkg::*;
#(
  parameter int unsigned WORD_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  output logic [WORD_W-OPC_W-1:0] mem_addr,
  output logic                    mem_rd,
  input  logic [WORD_W-1:0]       mem_rdata,
  output logic                    mem_wr,
  output logic [WORD_W-1:0]       mem_wdata,
  output logic                    halted
);

  localparam int unsigned ADDR_W = WORD_W - OPC_W;

  seq_ctl_t          ctl;
  logic [OPC_W-1:0]  ir_opc;
  logic [WORD_W-1:0] acc, mbr, alu_y;
  logic [ADDR_W-1:0] ear;

  acc_seq_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .opc    (ir_opc),
    .ctl    (ctl),
    .halted (halted)
  );

  acc_regs #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (ctl),
    .mem_rdata (mem_rdata),
    .alu_y     (alu_y),
    .ear       (ear),
    .acc       (acc),
    .mbr       (mbr),
    .ir_opc    (ir_opc)
  );

  acc_alu #(.WORD_W(WORD_W)) u_alu (
    .opc    (ir_opc),
    .acc_in (acc),
    .opnd   (mbr),
    .result (alu_y)
  );

  assign mem_addr  = ear;
  assign mem_rd    = ctl.rd;
  assign mem_wr    = ctl.wr;
  assign mem_wdata = acc;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    !rst_n |-> (!mem_rd && !mem_wr && !halted));
  assert_wdata_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $stable(mem_wdata));

endmodule

// File: tb/tb_acc_cpu_core.sv
`timescale 1ns/1ps
module tb_acc_cpu_core;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic        mem_rd, mem_wr, halted;
  logic [15:0] mem_rdata, mem_wdata;

  always #2.5 clk = ~clk;

  acc_cpu_core dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rd(mem_rd),
    .mem_rdata(mem_rdata), .mem_wr(mem_wr), .mem_wdata(mem_wdata), .halted(halted)
  );

  logic [15:0] mem [0:255];
  logic [15:0] rdata_q = 16'h0;
  assign mem_rdata = rdata_q;

  logic        s_rd = 0, s_wr = 0;
  logic [11:0] s_addr = 0;
  logic [15:0] s_wdata = 0;

  int n_cmp = 0, n_bad = 0;
  int ph = 0, r_pc = 0, r_acc = 0, r_ir = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_alu(input int op, input int a, input int b);
    case (op)
      1: return b;
      2: return (a + b) % 65536;
      3: return (a - b + 65536) % 65536;
      4: return a & b;
      default: return a;
    endcase
  endfunction

  // memory with one cycle of read latency, acting on values sampled mid-cycle
  always @(posedge clk) begin
    if (s_rd) rdata_q <= mem[s_addr[7:0]];
    if (s_wr) mem[s_addr[7:0]] = s_wdata;
    if (!rst_n) begin
      ph = 0; r_pc = 0; r_acc = 0; r_ir = 0;
    end else begin
      case (ph)
        0, 1, 2, 3, 6, 7: ph = ph + 1;
        4: begin r_ir = int'(mem[r_pc % 256]); r_pc = (r_pc + 1) % 4096; ph = 5; end
        5: begin
          case (r_ir >> 12)
            0: ph = 100;
            5: ph = 9;
            1, 2, 3, 4: ph = 6;
            default: ph = 0;
          endcase
        end
        8: begin
          r_acc = model_alu(r_ir >> 12, r_acc, int'(mem[r_ir % 256]));
          ph = 0;
        end
        9: ph = 0;
        default: ph = 100;
      endcase
    end
  end

  always @(negedge clk) begin
    s_rd = mem_rd; s_wr = mem_wr; s_addr = mem_addr; s_wdata = mem_wdata;
    if (!rst_n) begin
      check(!halted && !mem_rd && !mem_wr, "R1 quiet in reset",
            {halted, mem_rd, mem_wr}, 0);
    end else begin
      check(halted == (ph == 100), "R10 halted", halted, ph == 100);
      check(mem_rd == (ph == 1 || ph == 6), (ph == 6) ? "R4 operand read" : "R2 fetch read",
            mem_rd, (ph == 1 || ph == 6));
      check(mem_wr == (ph == 9), "R9 write strobe", mem_wr, ph == 9);
      if (ph == 1) check(mem_addr == r_pc, "R3 fetch address", mem_addr, r_pc);
      if (ph == 6) check(mem_addr == (r_ir % 4096), "R4 operand address", mem_addr, r_ir % 4096);
      if (ph == 9) begin
        check(mem_addr == (r_ir % 4096), "R9 store address", mem_addr, r_ir % 4096);
        check(mem_wdata == r_acc, "R9 store data", mem_wdata, r_acc);
      end
    end
  end

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic wait_halt(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (halted) break;
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    check(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // program A: arithmetic, stores, undefined opcodes, halt
    clear_mem();
    mem[0] = 16'h1040; mem[1] = 16'h5050; mem[2] = 16'h2041; mem[3] = 16'h5051;
    mem[4] = 16'h3042; mem[5] = 16'h5052; mem[6] = 16'h4043; mem[7] = 16'h9043;
    mem[8] = 16'hF055; mem[9] = 16'h5053; mem[10] = 16'h0000; mem[11] = 16'h5054;
    mem[8'h40] = 16'h1234; mem[8'h41] = 16'hF000; mem[8'h42] = 16'h0235;
    mem[8'h43] = 16'h0F0F; mem[8'h54] = 16'hDEAD;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    wait_halt(1000);
    check(halted == 1'b1, "R10 program A halted", halted, 1);
    check(mem[8'h50] == 16'h1234, "R5 load", mem[8'h50], 16'h1234);
    check(mem[8'h51] == 16'h0234, "R6 add wraps", mem[8'h51], 16'h0234);
    check(mem[8'h52] == 16'hFFFF, "R7 subtract borrows", mem[8'h52], 16'hFFFF);
    check(mem[8'h53] == 16'h0F0F, "R8 AND then R11 no-ops keep acc", mem[8'h53], 16'h0F0F);
    repeat (20) @(negedge clk);
    check(mem[8'h54] == 16'hDEAD, "R10 nothing after halt", mem[8'h54], 16'hDEAD);
    check(halted == 1'b1, "R10 halt sticky", halted, 1);

    // rerun A and reset partway
    #1 rst_n = 1'b0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (40) @(negedge clk);
    #1 rst_n = 1'b0;
    @(negedge clk);
    check(!halted && !mem_rd && !mem_wr, "R1 reset mid-run", {halted, mem_rd, mem_wr}, 0);

    // program B: acc cleared by reset, PC restarts at 0
    clear_mem();
    mem[0] = 16'h2061; mem[1] = 16'h5062; mem[2] = 16'hA000; mem[3] = 16'h3063;
    mem[4] = 16'h5064; mem[5] = 16'h0000;
    mem[8'h61] = 16'h0005; mem[8'h63] = 16'h0007;
    @(negedge clk);
    #1 rst_n = 1'b1;
    wait_halt(1000);
    check(mem[8'h62] == 16'h0005, "R1 acc zero after reset", mem[8'h62], 16'h0005);
    check(mem[8'h64] == 16'hFFFE, "R7 subtract below zero", mem[8'h64], 16'hFFFE);
    check(halted == 1'b1, "R10 program B halted", halted, 1);
    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule